// File: doc/BRIEF.md
# Addressed Parameter Command Parser

This block turns a stream of strobed 8-bit bytes into write requests for a 64-byte parameter RAM. The RAM holds 32 parameters of 12 bits each, and each parameter takes two bytes. The bytes may come from a serial receiver or from a parallel port.

A command opens with a start byte. A start byte is any value of 240 or more, and its low nibble names the target device. An address byte follows, and then one or two value bytes. The address byte selects the parameter and the byte mode. In two-byte mode the high part is written first and the low part second. In the single-byte modes only one of the two parts is written, which cuts line traffic.

Any start byte returns the parser to its idle state. As a result, traffic meant for other devices on a shared line never reaches this block's RAM. Each write is presented as a request that stays up until an arbiter in front of the RAM acknowledges it.

The controller has six states:

| State | Meaning |
|---|---|
| S_IDLE | Waiting for a start byte. |
| S_ADDR | Armed by a matching start byte; waiting for the address byte. |
| S_FIRST | Waiting for the first value byte. |
| S_SECOND | Waiting for the low value byte in two-byte mode. |
| S_WR_MID | The high part of a two-byte command is pending. |
| S_WR_LAST | The last write of a command is pending. |

Transitions:

- **Start byte, any state:** a matching start byte moves to S_ADDR. A start byte with another ID moves to S_IDLE. Both take priority over everything else.
- **S_ADDR:** the address byte moves to S_FIRST.
- **S_FIRST:** a value byte moves to S_WR_MID in two-byte mode, otherwise to S_WR_LAST.
- **S_SECOND:** a value byte moves to S_WR_LAST.
- **S_WR_MID:** an acknowledge moves to S_SECOND.
- **S_WR_LAST:** an acknowledge moves to S_IDLE.

Top module: `param_cmd_parser`

## Requirements
- R1: After reset the parser is idle and `wr_req` is low; no byte other than a matching start byte can lead to a write.
- R2: A start byte (value 0xF0 to 0xFF) whose low nibble equals `dev_id` arms the parser to take an address byte. A start byte with any other low nibble leaves it idle, and the non-start bytes that follow produce no write.
- R3: A start byte takes priority in every state. The strobe that carries it never counts as an address or value byte. A start byte received while a write is pending withdraws `wr_req` at the next cycle.
- R4: Bits 4:0 of the address byte pick the parameter p. When bit 7 is 1 (two-byte mode), the first value byte is written to RAM address {p,0} and the second to {p,1}.
- R5: When address bit 7 is 0, one value byte is written. Bit 6 = 1 sends it to the low location {p,1}, and bit 6 = 0 sends it to the high location {p,0}.
- R6: Written data are masked. At a high location (address bit 0 = 0) only bits 6:0 pass. At a low location (address bit 0 = 1) only bits 4:0 pass. All other bits are zero.
- R7: `wr_req` rises in the cycle after the strobe of a value byte. It stays high with `wr_addr` and `wr_data` unchanged up to and including the cycle in which `wr_ack` is sampled high, and is low in the cycle after that.
- R8: Non-start bytes that arrive while a write is pending are dropped. They change neither the pending write nor the rest of the command.
- R9: Once the last write of a command is acknowledged, the parser is idle. Further non-start bytes produce no write until a new matching start byte arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_id | input | 4 | This device's ID, compared with the start byte's low nibble |
| rx_byte | input | 8 | Received byte, valid while rx_stb is high |
| rx_stb | input | 1 | One-cycle strobe marking a new byte |
| wr_req | output | 1 | RAM write request, held until acknowledged |
| wr_addr | output | 6 | RAM byte address {parameter, part}; part 0 = high, 1 = low |
| wr_data | output | 8 | Masked byte to be written |
| wr_ack | input | 1 | Arbiter acknowledge of the pending write |

## Verification
Three properties are checked on every cycle:

- While `wr_req` waits for its acknowledge, address and data stay stable.
- A request never rises without a preceding byte strobe, an acknowledged request drops, and any start byte withdraws the request.
- Data at high and low locations carry no bits outside their masks.

The other behaviours need whole command sequences, so only the bench scenarios can show them:

- the mapping from the address byte to the RAM location in each mode;
- commands with a foreign ID and bare 0xF0 bytes being ignored;
- a restart in the middle of a command;
- bytes dropped during a pending write;
- silence after a completed command.

// File: rtl/pcp_pkg.sv
package pcp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_FIRST,
        S_SECOND,
        S_WR_MID,
        S_WR_LAST
    } pcp_state_e;

endpackage

// File: rtl/pcp_start_detect.sv
module pcp_start_detect #(
    parameter int BYTE_W = 8,
    parameter int ID_W   = 4
) (
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [ID_W-1:0]   dev_id,
    output logic              is_start,
    output logic              id_match
);
    localparam int TAG_W = BYTE_W - ID_W;

    // A start byte has every bit above the ID field set.
    always_comb begin
        is_start = &rx_byte[BYTE_W-1 -: TAG_W];
        id_match = is_start && (rx_byte[ID_W-1:0] == dev_id);
    end
endmodule

// File: rtl/pcp_fsm.sv
module pcp_fsm
    import pcp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_stb,
    input  logic is_start,
    input  logic id_match,
    input  logic full_mode,
    input  logic wr_ack,
    output logic cap_addr,
    output logic cap_val,
    output logic to_low,
    output logic wr_req
);
    pcp_state_e state_q, state_d;
    logic       start_seen;
    logic       byte_take;

    always_comb begin
        start_seen = rx_stb && is_start;
        byte_take  = rx_stb && !is_start;
    end

    // Next-state logic: a start byte overrides every other event.
    always_comb begin
        state_d = state_q;
        if (start_seen) begin
            state_d = id_match ? S_ADDR : S_IDLE;
        end else begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_ADDR:    if (byte_take) state_d = S_FIRST;
                S_FIRST:   if (byte_take) state_d = full_mode ? S_WR_MID : S_WR_LAST;
                S_SECOND:  if (byte_take) state_d = S_WR_LAST;
                S_WR_MID:  if (wr_ack)    state_d = S_SECOND;
                S_WR_LAST: if (wr_ack)    state_d = S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Control outputs decoded from the current state.
    always_comb begin
        cap_addr = 1'b0;
        cap_val  = 1'b0;
        to_low   = 1'b0;
        wr_req   = 1'b0;
        unique case (state_q)
            S_IDLE:    ;
            S_ADDR:    cap_addr = byte_take;
            S_FIRST:   cap_val  = byte_take;
            S_SECOND:  cap_val  = byte_take;
            S_WR_MID:  begin
                wr_req = 1'b1;
                to_low = wr_ack && !start_seen;
            end
            S_WR_LAST: wr_req = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/pcp_fields.sv
module pcp_fields #(
    parameter int BYTE_W  = 8,
    parameter int PAW     = 5,
    parameter int HI_BITS = 7,
    parameter int LO_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              cap_addr,
    input  logic              cap_val,
    input  logic              to_low,
    output logic              full_mode,
    output logic [PAW:0]      wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int          FULL_BIT = BYTE_W - 1;
    localparam int          LOW_BIT  = BYTE_W - 2;
    localparam logic [BYTE_W-1:0] HI_MASK = BYTE_W'((1 << HI_BITS) - 1);
    localparam logic [BYTE_W-1:0] LO_MASK = BYTE_W'((1 << LO_BITS) - 1);

    logic [PAW-1:0]    param_q;
    logic              sel_q;
    logic [BYTE_W-1:0] data_q;
    logic              full_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            param_q <= '0;
            sel_q   <= 1'b0;
            full_q  <= 1'b0;
            data_q  <= '0;
        end else begin
            if (cap_addr) begin
                param_q <= rx_byte[PAW-1:0];
                full_q  <= rx_byte[FULL_BIT];
                sel_q   <= rx_byte[FULL_BIT] ? 1'b0 : rx_byte[LOW_BIT];
            end
            if (to_low) begin
                sel_q <= 1'b1;
            end
            if (cap_val) begin
                data_q <= rx_byte & (sel_q ? LO_MASK : HI_MASK);
            end
        end
    end

    always_comb begin
        full_mode = full_q;
        wr_addr   = {param_q, sel_q};
        wr_data   = data_q;
    end
endmodule

// File: rtl/param_cmd_parser.sv
module param_cmd_parser #(
    parameter int N_PARAMS = 32,
    parameter int BYTE_W   = 8,
    parameter int ID_W     = 4,
    parameter int HI_BITS  = 7,
    parameter int LO_BITS  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dev_id,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_stb,
    output logic              wr_req,
    output logic [$clog2(N_PARAMS):0] wr_addr,
    output logic [BYTE_W-1:0] wr_data,
    input  logic              wr_ack
);
    localparam int PAW = $clog2(N_PARAMS);

    logic is_start, id_match, full_mode;
    logic cap_addr, cap_val, to_low;

    pcp_start_detect #(.BYTE_W(BYTE_W), .ID_W(ID_W)) u_start (
        .rx_byte  (rx_byte),
        .dev_id   (dev_id),
        .is_start (is_start),
        .id_match (id_match)
    );

    pcp_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_stb    (rx_stb),
        .is_start  (is_start),
        .id_match  (id_match),
        .full_mode (full_mode),
        .wr_ack    (wr_ack),
        .cap_addr  (cap_addr),
        .cap_val   (cap_val),
        .to_low    (to_low),
        .wr_req    (wr_req)
    );

    pcp_fields #(
        .BYTE_W (BYTE_W),
        .PAW    (PAW),
        .HI_BITS(HI_BITS),
        .LO_BITS(LO_BITS)
    ) u_fields (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_byte   (rx_byte),
        .cap_addr  (cap_addr),
        .cap_val   (cap_val),
        .to_low    (to_low),
        .full_mode (full_mode),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );
endmodule

// File: rtl/pcp_checker.sv
module pcp_checker #(
    parameter int PAW     = 5,
    parameter int BYTE_W  = 8,
    parameter int ID_W    = 4,
    parameter int HI_BITS = 7,
    parameter int LO_BITS = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [BYTE_W-1:0] rx_byte,
    input logic              rx_stb,
    input logic              wr_req,
    input logic [PAW:0]      wr_addr,
    input logic [BYTE_W-1:0] wr_data,
    input logic              wr_ack
);
    logic start_in;
    always_comb start_in = rx_stb && (&rx_byte[BYTE_W-1 -: (BYTE_W-ID_W)]);

    // R1: a cycle in reset leaves no request behind
    a_r1_reset_quiet: assert property (@(posedge clk) !rst_n |=> !wr_req);

    // R3: any start byte withdraws a pending request
    a_r3_start_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        start_in |=> !wr_req);

    // R7 and R8: an unacknowledged request holds address and data
    a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack && !start_in) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    // R7: an acknowledged request is released
    a_r7_release: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);

    // R7: a request only rises after a byte strobe
    a_r7_rise_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req) |-> $past(rx_stb));

    // R6: high locations carry only HI_BITS of data
    a_r6_high_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_addr[0]) |-> ((wr_data >> HI_BITS) == '0));

    // R6: low locations carry only LO_BITS of data
    a_r6_low_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_addr[0]) |-> ((wr_data >> LO_BITS) == '0));
endmodule

bind param_cmd_parser pcp_checker #(
    .PAW    (PAW),
    .BYTE_W (BYTE_W),
    .ID_W   (ID_W),
    .HI_BITS(HI_BITS),
    .LO_BITS(LO_BITS)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_byte (rx_byte),
    .rx_stb  (rx_stb),
    .wr_req  (wr_req),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_ack  (wr_ack)
);

// File: tb/param_cmd_parser_tb_top.sv
module param_cmd_parser_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] dev_id = 4'h5;
    logic [7:0] rx_byte = 8'h00;
    logic       rx_stb = 1'b0;
    logic       wr_ack = 1'b0;
    logic       wr_req;
    logic [5:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    param_cmd_parser dut_i (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
        .rx_byte(rx_byte), .rx_stb(rx_stb),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ack(wr_ack)
    );

    typedef struct packed {
        logic [7:0] st;
        logic [7:0] ad;
        logic [7:0] v1;
        logic [7:0] v2;
        logic       two;
        logic [5:0] a1;
        logic [7:0] d1;
        logic [5:0] a2;
        logic [7:0] d2;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VEC [NV] = '{
        '{8'hF5, 8'h83, 8'h7F, 8'h1F, 1'b1, 6'h06, 8'h7F, 6'h07, 8'h1F},
        '{8'hF5, 8'h9F, 8'h55, 8'h7A, 1'b1, 6'h3E, 8'h55, 6'h3F, 8'h1A},
        '{8'hF5, 8'h0A, 8'h6C, 8'h00, 1'b0, 6'h14, 8'h6C, 6'h00, 8'h00},
        '{8'hF5, 8'h4A, 8'h3E, 8'h00, 1'b0, 6'h15, 8'h1E, 6'h00, 8'h00},
        '{8'hF5, 8'h80, 8'h00, 8'h00, 1'b1, 6'h00, 8'h00, 6'h01, 8'h00},
        '{8'hF5, 8'h11, 8'hEF, 8'h00, 1'b0, 6'h22, 8'h6F, 6'h00, 8'h00}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Drive one strobed byte; returns at the negedge after it was registered.
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b;
        rx_stb  = 1'b1;
        @(negedge clk);
        rx_stb  = 1'b0;
    endtask

    task automatic expect_write(input string req, input logic [5:0] a, input logic [7:0] d);
        check(req, {31'd0, wr_req}, 32'd1);
        check(req, {26'd0, wr_addr}, {26'd0, a});
        check(req, {24'd0, wr_data}, {24'd0, d});
    endtask

    task automatic ack;
        wr_ack = 1'b1;
        @(negedge clk);
        wr_ack = 1'b0;
    endtask

    task automatic idle_for(input string req, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            check(req, {31'd0, wr_req}, 32'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", {31'd0, wr_req}, 32'd0);
        rst_n = 1'b1;
        idle_for("R1", 2);
        // R1: value bytes with no start byte do nothing
        send(8'h83);
        send(8'h22);
        idle_for("R1", 2);

        // R4 R5 R6 R7 R9: vector table
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = VEC[i].two ? "R4 R6" : "R5 R6";
            send(VEC[i].st);
            send(VEC[i].ad);
            check("R7", {31'd0, wr_req}, 32'd0);
            send(VEC[i].v1);
            expect_write(tg, VEC[i].a1, VEC[i].d1);
            ack;
            check("R7", {31'd0, wr_req}, 32'd0);
            if (VEC[i].two) begin
                send(VEC[i].v2);
                expect_write(tg, VEC[i].a2, VEC[i].d2);
                ack;
                check("R7", {31'd0, wr_req}, 32'd0);
            end
            send(8'h33);
            idle_for("R9", 2);
        end

        // R2: foreign ID is ignored
        send(8'hF3);
        send(8'h83);
        send(8'h40);
        send(8'h11);
        idle_for("R2", 3);

        // R2: bare 0xF0 mid-command resets
        send(8'hF5);
        send(8'h83);
        send(8'hF0);
        send(8'h40);
        idle_for("R2", 3);

        // R3: restart mid-command; repeated start byte is not an address
        send(8'hF5);
        send(8'h83);
        send(8'hF5);
        send(8'hF5);
        send(8'h0A);
        send(8'h22);
        expect_write("R3", 6'h14, 8'h22);
        ack;

        // R7: request held until ack
        send(8'hF5);
        send(8'h45);
        send(8'h13);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            expect_write("R7", 6'h0B, 8'h13);
        end
        ack;
        check("R7", {31'd0, wr_req}, 32'd0);

        // R8: bytes during a pending write are dropped
        send(8'hF5);
        send(8'h82);
        send(8'h2A);
        send(8'h11);
        expect_write("R8", 6'h04, 8'h2A);
        ack;
        check("R8", {31'd0, wr_req}, 32'd0);
        send(8'h09);
        expect_write("R8", 6'h05, 8'h09);
        ack;

        // R3: start byte cancels a pending write
        send(8'hF5);
        send(8'h0A);
        send(8'h22);
        expect_write("R3", 6'h14, 8'h22);
        send(8'hF5);
        check("R3", {31'd0, wr_req}, 32'd0);
        send(8'h4B);
        send(8'h03);
        expect_write("R3", 6'h17, 8'h03);
        ack;
        idle_for("R9", 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule